// File: doc/BRIEF.md
# Byte-Wide Output Port with Delayed Ready Strobe

This block is the output half of a parallel port on an 8-bit microcomputer. When the CPU writes to the port address, the block takes a byte from the internal data bus into a holding register. It then tells an external device, through an active-low ready line, that a new byte is waiting. The ready line does not go low on the write itself. It waits for the next falling edge of the phase-2 CPU clock, so the register outputs have time to settle before the device looks at them. The line then stays low for the rest of the bus cycle and is released partway through the sync pulse of the following cycle.

The register drives the connector through tri-state buffers. The block does not contain the buffers. It provides the data value and an enable, and the pad ring builds the driver from them. An external float request lets the attached device turn the drivers off when it shares a bidirectional bus. The request line rests at its inactive level, so a port with nothing attached drives its pins.

All inputs are sampled with one fast system clock. The phase-2 clock and the sync pulse arrive as ordinary level inputs, and their edges are found by comparing each sample with the one taken on the previous system clock.

Top module: `par_out_port`

## Requirements
- R1: A synchronous reset sets the held byte to REG_RST (default 0) and holds the ready line high (inactive).
- R2: The system clock edge that first sees the write select high, after it was low on the previous edge, loads bus_din into the held byte. The new value appears on pins_dout after that edge.
- R3: Changes on bus_din while the write select stays high, or while it stays low, leave the held byte unchanged.
- R4: After a write leading edge, rdy_n stays high until phi2 is seen low on an edge where it was high on the previous edge. rdy_n goes low after that edge.
- R5: Once low, rdy_n stays low across any number of phi2 edges while sync is low.
- R6: While rdy_n is low, an edge that sees phi2 rising (low on the previous edge, high now) with sync high drives rdy_n high after that edge.
- R7: pins_oe is 1 (drive the pins) whenever the float request is inactive. With FLOAT_ACT_LOW=1 (default) the request float_req is active at 0, so float_req=1 gives pins_oe=1 and float_req=0 gives pins_oe=0.
- R8: A write leading edge takes priority over everything else. It re-arms the strobe, so rdy_n goes high (or stays high) after that edge, including on an edge that would otherwise clear it. rdy_n falls again only at the next phi2 falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register in the block updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phi2 | input | 1 | Phase-2 CPU clock, sampled as a level |
| sync | input | 1 | Bus-cycle sync pulse, active high |
| port_we | input | 1 | Port-write select, active high |
| bus_din | input | DATA_W | Internal data bus |
| float_req | input | 1 | External request to float the pins; its polarity is set by FLOAT_ACT_LOW |
| pins_dout | output | DATA_W | Held byte for the connector drivers |
| pins_oe | output | 1 | Driver enable for the connector pins, 1 = drive |
| rdy_n | output | 1 | Output-ready strobe, active low |

## Verification
The hardest cases to reach are the ones where a write leading edge lands on the same system-clock edge as a phi2 rise with sync high, or where a new write arrives while the strobe is already held low. In both cases the write has to win. With random timing these coincidences are rare, so the bench steers the phi2 and sync levels by hand to make them happen, and it checks rdy_n on the edge where the write lands and again on the phi2 falling edge after it. After that, a long random run uses a free-running phi2, random sync pulses, random writes and random float requests. Every cycle is compared against a bench model.

// File: rtl/pop_pkg.sv
package pop_pkg;
   typedef enum logic [1:0] {
      STB_IDLE  = 2'd0,
      STB_ARMED = 2'd1,
      STB_HELD  = 2'd2
   } stb_state_t;
endpackage

// File: rtl/pop_edge_det.sv
module pop_edge_det #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic [W-1:0] sig,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) prev_q <= sig;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign rise[i] = sig[i] & ~prev_q[i];
      assign fall[i] = ~sig[i] & prev_q[i];
   end
endmodule

// File: rtl/pop_data_reg.sv
module pop_data_reg #(
   parameter int          DATA_W  = 8,
   parameter logic [DATA_W-1:0] REG_RST = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (rst)       dout <= REG_RST;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/pop_strobe_ctl.sv
module pop_strobe_ctl
   import pop_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic phase_fall,
   input  logic phase_rise,
   input  logic sync,
   output logic rdy_n
);
   stb_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (arm) begin
         st_d = STB_ARMED;
      end else begin
         unique case (st_q)
            STB_ARMED: if (phase_fall)          st_d = STB_HELD;
            STB_HELD:  if (phase_rise && sync)  st_d = STB_IDLE;
            default:                            st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= STB_IDLE;
      else     st_q <= st_d;
   end

   assign rdy_n = (st_q != STB_HELD);
endmodule

// File: rtl/par_out_port.sv
module par_out_port #(
   parameter int                DATA_W        = 8,
   parameter logic [DATA_W-1:0] REG_RST       = '0,
   parameter bit                FLOAT_ACT_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              phi2,
   input  logic              sync,
   input  logic              port_we,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              float_req,
   output logic [DATA_W-1:0] pins_dout,
   output logic              pins_oe,
   output logic              rdy_n
);
   localparam int N_EDGE = 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("par_out_port: DATA_W must be at least 1");
   end

   logic [N_EDGE-1:0] edge_in, edge_rise, edge_fall;
   assign edge_in = {phi2, port_we};

   pop_edge_det #(.W(N_EDGE)) u_edges (
      .clk  (clk),
      .sig  (edge_in),
      .rise (edge_rise),
      .fall (edge_fall)
   );

   logic wr_lead;
   assign wr_lead = edge_rise[0];

   pop_data_reg #(.DATA_W(DATA_W), .REG_RST(REG_RST)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (wr_lead),
      .din  (bus_din),
      .dout (pins_dout)
   );

   pop_strobe_ctl u_stb (
      .clk        (clk),
      .rst        (rst),
      .arm        (wr_lead),
      .phase_fall (edge_fall[1]),
      .phase_rise (edge_rise[1]),
      .sync       (sync),
      .rdy_n      (rdy_n)
   );

   if (FLOAT_ACT_LOW) begin : g_float_low
      assign pins_oe = float_req;
   end else begin : g_float_high
      assign pins_oe = ~float_req;
   end
endmodule

// File: rtl/par_out_port_chk.sv
module par_out_port_chk #(
   parameter int DATA_W        = 8,
   parameter bit FLOAT_ACT_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              phi2,
   input logic              sync,
   input logic              port_we,
   input logic [DATA_W-1:0] bus_din,
   input logic              float_req,
   input logic [DATA_W-1:0] pins_dout,
   input logic              pins_oe,
   input logic              rdy_n
);
   logic rst_seen_q = 1'b0;
   always_ff @(posedge clk) rst_seen_q <= rst;

   always @(posedge clk) begin
      if (rst_seen_q) begin
         AST_RESET_RDY: assert (rdy_n === 1'b1);  // R1
      end
   end

   AST_LOAD_ON_LEAD: assert property (@(posedge clk) disable iff (rst)
      (port_we && !$past(port_we)) |=> (pins_dout == $past(bus_din)));  // R2

   AST_HOLD_NO_LEAD: assert property (@(posedge clk) disable iff (rst)
      !(port_we && !$past(port_we)) |=> $stable(pins_dout));  // R3

   AST_FALL_ON_PHASE: assert property (@(posedge clk) disable iff (rst)
      $fell(rdy_n) |-> (!$past(phi2) && $past(phi2, 2)));  // R4

   AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy_n) |-> (($past(phi2) && $past(sync) && !$past(phi2, 2)) ||
                        ($past(port_we) && !$past(port_we, 2))));  // R6

   AST_LOW_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
      (!rdy_n && !sync && !(port_we && !$past(port_we))) |=> !rdy_n);  // R5

   AST_LEAD_RELEASES: assert property (@(posedge clk) disable iff (rst)
      (port_we && !$past(port_we)) |=> rdy_n);  // R8

   AST_PIN_ENABLE: assert property (@(posedge clk) disable iff (rst)
      pins_oe == (FLOAT_ACT_LOW ? float_req : !float_req));  // R7
endmodule

bind par_out_port par_out_port_chk #(
   .DATA_W(DATA_W), .FLOAT_ACT_LOW(FLOAT_ACT_LOW)
) u_chk (
   .clk(clk), .rst(rst), .phi2(phi2), .sync(sync), .port_we(port_we),
   .bus_din(bus_din), .float_req(float_req), .pins_dout(pins_dout),
   .pins_oe(pins_oe), .rdy_n(rdy_n)
);

// File: tb/par_out_port_tb.sv
module par_out_port_tb;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst, phi2, sync, port_we, float_req;
   logic [DW-1:0] bus_din;
   logic [DW-1:0] pins_dout;
   logic          pins_oe, rdy_n;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   par_out_port #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst(rst), .phi2(phi2), .sync(sync), .port_we(port_we),
      .bus_din(bus_din), .float_req(float_req), .pins_dout(pins_dout),
      .pins_oe(pins_oe), .rdy_n(rdy_n)
   );

   // bench model built from the requirements
   logic [DW-1:0] m_data;
   int            m_st;      // 0 idle, 1 armed, 2 held
   logic          m_wr_p, m_ph_p;

   function automatic int next_st(int st, bit lead, bit pf, bit pr, bit sy);
      if (lead)              return 1;   // R8 write wins
      if (st == 1 && pf)     return 2;   // R4
      if (st == 2 && pr && sy) return 0; // R6
      return st;                          // R5
   endfunction

   function automatic bit exp_oe(bit fr);
      return fr;                          // R7: active-low request
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_data = '0;
         m_st   = 0;
      end else begin
         m_st = next_st(m_st, port_we && !m_wr_p, !phi2 && m_ph_p,
                        phi2 && !m_ph_p, sync);
         if (port_we && !m_wr_p) m_data = bus_din;
      end
      m_wr_p = port_we;
      m_ph_p = phi2;
   end

   task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      #1_900_000;
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      rst = 1; phi2 = 1; sync = 0; port_we = 0; float_req = 1; bus_din = '0;
      repeat (3) tick();
      check("R1 data", pins_dout, 8'h00);
      check("R1 rdy", {7'd0, rdy_n}, 8'd1);
      rst = 0;
      tick();

      // R2 / R3 / R4
      bus_din = 8'hA5; port_we = 1; tick();
      check("R2 load", pins_dout, 8'hA5);
      check("R4 waits", {7'd0, rdy_n}, 8'd1);
      bus_din = 8'h3C; tick();
      check("R3 held-high", pins_dout, 8'hA5);
      port_we = 0; tick();
      check("R3 held-low", pins_dout, 8'hA5);
      check("R4 no phase", {7'd0, rdy_n}, 8'd1);
      phi2 = 0; tick();
      check("R4 fall", {7'd0, rdy_n}, 8'd0);
      // R5
      phi2 = 1; tick(); check("R5 rise nosync", {7'd0, rdy_n}, 8'd0);
      phi2 = 0; tick(); check("R5 fall", {7'd0, rdy_n}, 8'd0);
      // R6
      sync = 1; phi2 = 1; tick();
      check("R6 clear", {7'd0, rdy_n}, 8'd1);
      sync = 0; tick();

      // R8 new write while held
      bus_din = 8'h11; port_we = 1; tick();
      port_we = 0; phi2 = 0; tick();
      check("R8 pre held", {7'd0, rdy_n}, 8'd0);
      phi2 = 1; tick();
      bus_din = 8'h22; port_we = 1; tick();
      check("R8 rearm", {7'd0, rdy_n}, 8'd1);
      check("R8 data", pins_dout, 8'h22);
      port_we = 0; phi2 = 0; tick();
      check("R8 refall", {7'd0, rdy_n}, 8'd0);

      // R8 write coincides with clearing edge
      sync = 1; phi2 = 1; bus_din = 8'h33; port_we = 1; tick();
      check("R8 coincide", {7'd0, rdy_n}, 8'd1);
      port_we = 0; sync = 0; phi2 = 0; tick();
      check("R8 coincide fall", {7'd0, rdy_n}, 8'd0);
      sync = 1; phi2 = 1; tick();
      check("R6 clear2", {7'd0, rdy_n}, 8'd1);
      sync = 0;

      // R7
      float_req = 0; #1;
      check("R7 float", {7'd0, pins_oe}, 8'd0);
      float_req = 1; #1;
      check("R7 drive", {7'd0, pins_oe}, 8'd1);
      tick();

      // random run against the model
      for (int i = 0; i < 4000; i++) begin
         check("R2 rand data", pins_dout, m_data);
         check("R4 rand rdy", {7'd0, rdy_n}, {7'd0, m_st != 2});
         check("R7 rand oe", {7'd0, pins_oe}, {7'd0, exp_oe(float_req)});
         if (i % 2 == 0) phi2 = ~phi2;
         sync      = ($urandom % 4) == 0;
         port_we   = ($urandom % 6) == 0;
         bus_din   = DW'($urandom);
         float_req = ($urandom % 8) != 0;
         tick();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule